// File: doc/BRIEF.md
# Fractional-Rate SPI Master Shifter

This block is a full-duplex SPI master for 8-bit frames. A fractional divider turns the system clock into a tick enable. A sequencer spends four ticks on every serial bit, and it drives the serial clock and the outgoing data line. It also samples the incoming data line. Bytes to send enter through a transmit queue with a valid/ready handshake. Every byte sent yields one received byte, which leaves through a receive queue with the same kind of handshake.

Clock polarity and clock phase can be chosen at run time. The polarity is applied only as an inversion of the clock output. The sequencer always treats its own low level as idle. When the transmit queue is empty at the end of a byte, the engine parks with the clock idle and sets a sticky stall flag. That flag stays set until it is read. The combination of an empty transmit queue, a set flag and a parked engine is reported as the end of a transfer.

To change the rate or the mode, software drops the enable, makes the change and raises the enable again. The engine then restarts from its parked state.

Top module: `spi_frac_shifter`

## Requirements
- R1: After reset, `sck` equals `cpol`, `mosi` is 0, `tx_ready` is 1, and `rx_valid`, `stall_flag` and `idle` are all 0.
- R2: The rate value is r = max(`div_int`,1) + `div_frac`/256. An accumulator gains 1.0 in each enabled cycle. A tick occurs in a cycle where the accumulator has reached r, and r is then subtracted from it. Each serial bit spans exactly four ticks.
- R3: With `cpha`=0, the four ticks of a bit are numbered 0 to 3. `mosi` takes the new bit on entry to tick 0. The internal clock is low in ticks 0–1 and high in ticks 2–3. `miso` is sampled on entry to tick 2.
- R4: With `cpha`=1, the internal clock is low in tick 0, high in ticks 1–2 and low in tick 3. `mosi` takes the new bit on entry to tick 1, and `miso` is sampled on entry to tick 3.
- R5: `sck` is the internal clock XOR `cpol`. Whenever the engine is parked, `sck` equals `cpol`.
- R6: Frames are 8 bits, sent and received MSB first. A byte is pulled from the transmit queue at a byte boundary. Each completed frame is pushed to the receive queue. In loopback, bytes come back unchanged and in order.
- R7: `stall_flag` is set when the last bit of a byte ends while the transmit queue is empty. It stays set until a cycle with `stall_rd`=1 clears it, and a set in the same cycle wins over the clear. While stalled, `sck` is idle.
- R8: `idle` is 1 exactly when the engine is parked, the transmit queue is empty and `stall_flag` is set.
- R9: A new byte starts only if the receive queue still has room for it once the current byte has been pushed. No received byte is dropped. While held for room, `sck` is idle and `stall_flag` is not set by this hold.
- R10: With `en`=0, the engine is parked from the next cycle, with `sck` idle. The accumulator and bit position are cleared and a partly shifted byte is discarded.
- R11: `tx_ready` is 1 while the transmit queue (FIFO_DEPTH entries) is not full. `rx_valid` is 1 while the receive queue is not empty, and `rx_data` shows its oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable; low parks the engine and clears the divider |
| cpol | input | 1 | Clock polarity (idle level of sck) |
| cpha | input | 1 | Clock phase select |
| div_int | input | DIV_INT_W | Integer part of the rate value (0 acts as 1) |
| div_frac | input | DIV_FRAC_W | Fractional part of the rate value, in 1/256 |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit queue can accept |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| stall_rd | input | 1 | Read strobe that clears the stall flag |
| stall_flag | output | 1 | Sticky end-of-data stall indication |
| idle | output | 1 | Transfer finished |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A queue handshake shows up on `tx_ready`/`rx_valid` one clock after the accepting edge. Pin changes of `sck` and `mosi` appear one clock after the tick that causes them. A received byte becomes visible one clock after the tick that ends its eighth bit, and `stall_flag` and `idle` change in the same cycle as that push. The bench advances a behavioural reference on each rising edge from the inputs held since the previous falling edge. It compares every output at the falling edge, so each expectation is sampled in the cycle after the edge that produces it. A loopback scoreboard separately matches each popped byte against the bytes offered, with `miso` tied to `mosi` or to its inverse.

// File: rtl/spifs_pkg.sv
package spifs_pkg;
   localparam int FRAME_W       = 8;
   localparam int TICKS_PER_BIT = 4;
   localparam int SLOT_W        = $clog2(TICKS_PER_BIT);
   localparam int BIT_W         = $clog2(FRAME_W);

   typedef logic [FRAME_W-1:0] frame_t;
   typedef logic [SLOT_W-1:0]  slot_t;
endpackage

// File: rtl/spifs_tick_div.sv
module spifs_tick_div #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);
   localparam int ACC_W = INT_W + FRAC_W + 1;
   localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

   logic [INT_W-1:0] int_eff;
   logic [ACC_W-1:0] ratio;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;

   assign int_eff = (div_int == '0) ? INT_W'(1) : div_int;
   assign ratio   = {1'b0, int_eff, div_frac};
   assign sum     = acc_q + ONE;
   assign tick    = en && (sum >= ratio);

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (!en)    acc_q <= '0;
      else if (tick)   acc_q <= sum - ratio;
      else             acc_q <= sum;
   end
endmodule

// File: rtl/spifs_fifo.sv
module spifs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic [W-1:0]     out_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [CNT_W-1:0] count
);
   logic push, pop;
   assign push = in_valid && in_ready;
   assign pop  = out_valid && out_ready;

   generate
      if (DEPTH == 1) begin : g_single
         logic         full_q;
         logic [W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     full_q <= 1'b0;
            else if (push)  full_q <= 1'b1;
            else if (pop)   full_q <= 1'b0;
         end
         always_ff @(posedge clk) begin
            if (push) data_q <= in_data;
         end
         assign in_ready  = !full_q || pop;
         assign out_valid = full_q;
         assign out_data  = data_q;
         assign count     = CNT_W'(full_q);
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wr_q, rd_q;
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wr_q <= wr_q + PTR_W'(1);
               if (pop)  rd_q <= rd_q + PTR_W'(1);
               case ({push, pop})
                  2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                  2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wr_q] <= in_data;
         end
         assign in_ready  = (cnt_q != CNT_W'(DEPTH));
         assign out_valid = (cnt_q != '0);
         assign out_data  = mem[rd_q];
         assign count     = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/spifs_seq.sv
module spifs_seq
   import spifs_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cpha,
   input  logic             tick,
   input  logic             tx_avail,
   input  frame_t           tx_byte,
   output logic             tx_take,
   input  logic [CNT_W-1:0] rx_count,
   output logic             rx_put,
   output frame_t           rx_byte,
   input  logic             miso,
   output logic             sck_int,
   output logic             mosi,
   output logic             stall_set,
   output logic             running
);
   localparam slot_t LAST_SLOT = SLOT_W'(TICKS_PER_BIT - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   logic             run_q;
   slot_t            slot_q;
   logic [BIT_W-1:0] bit_q;
   frame_t           tx_sh, rx_sh;
   logic             mosi_q;
   logic             last_slot, at_boundary, capture, rx_room;
   logic [CNT_W:0]   rx_need;

   assign last_slot   = run_q && (slot_q == LAST_SLOT) && (bit_q == LAST_BIT);
   assign at_boundary = !run_q || last_slot;
   assign rx_put      = tick && last_slot;
   assign rx_need     = {1'b0, rx_count} + (CNT_W+1)'(rx_put);
   assign rx_room     = rx_need < (CNT_W+1)'(FIFO_DEPTH);
   assign tx_take     = tick && at_boundary && tx_avail && rx_room;
   assign stall_set   = tick && last_slot && !tx_avail;
   assign capture     = cpha ? (slot_q == SLOT_W'(2)) : (slot_q == SLOT_W'(1));
   assign rx_byte     = rx_sh;
   assign mosi        = mosi_q;
   assign running     = run_q;
   assign sck_int     = run_q && (cpha ? (slot_q == SLOT_W'(1) || slot_q == SLOT_W'(2))
                                       : slot_q[SLOT_W-1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         slot_q <= '0;
         bit_q  <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         mosi_q <= 1'b0;
      end else if (!en) begin
         run_q  <= 1'b0;
         slot_q <= '0;
         bit_q  <= '0;
      end else if (tick) begin
         if (at_boundary) begin
            slot_q <= '0;
            bit_q  <= '0;
            run_q  <= tx_take;
            if (tx_take) begin
               tx_sh <= tx_byte;
               if (!cpha) mosi_q <= tx_byte[FRAME_W-1];
            end
         end else begin
            if (capture) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
            if (cpha && slot_q == '0) mosi_q <= tx_sh[FRAME_W-1];
            if (slot_q == LAST_SLOT) begin
               slot_q <= '0;
               bit_q  <= bit_q + BIT_W'(1);
               tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
               if (!cpha) mosi_q <= tx_sh[FRAME_W-2];
            end else begin
               slot_q <= slot_q + SLOT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spi_frac_shifter.sv
module spi_frac_shifter
   import spifs_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_INT_W  = 16,
   parameter int DIV_FRAC_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  cpol,
   input  logic                  cpha,
   input  logic [DIV_INT_W-1:0]  div_int,
   input  logic [DIV_FRAC_W-1:0] div_frac,
   input  logic [7:0]            tx_data,
   input  logic                  tx_valid,
   output logic                  tx_ready,
   output logic [7:0]            rx_data,
   output logic                  rx_valid,
   input  logic                  rx_ready,
   input  logic                  stall_rd,
   output logic                  stall_flag,
   output logic                  idle,
   output logic                  sck,
   output logic                  mosi,
   input  logic                  miso
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 1 || (FIFO_DEPTH > 1 && (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)) begin : g_bad_depth
         initial $error("FIFO_DEPTH must be 1 or a power of two");
      end
      if (DIV_FRAC_W < 1 || DIV_INT_W < 1) begin : g_bad_div
         initial $error("divider widths must be at least one bit");
      end
   endgenerate

   logic             tick, tx_take, rx_put, stall_set, running, sck_int;
   logic             tx_out_valid;
   frame_t           tx_head, rx_byte;
   logic [CNT_W-1:0] tx_count, rx_count;
   logic             stall_q;

   spifs_tick_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(en),
      .div_int(div_int), .div_frac(div_frac), .tick(tick)
   );

   spifs_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
      .out_data(tx_head), .out_valid(tx_out_valid), .out_ready(tx_take),
      .count(tx_count)
   );

   spifs_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .in_data(rx_byte), .in_valid(rx_put), .in_ready(),
      .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready),
      .count(rx_count)
   );

   spifs_seq #(.FIFO_DEPTH(FIFO_DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .cpha(cpha), .tick(tick),
      .tx_avail(tx_out_valid), .tx_byte(tx_head), .tx_take(tx_take),
      .rx_count(rx_count), .rx_put(rx_put), .rx_byte(rx_byte),
      .miso(miso), .sck_int(sck_int), .mosi(mosi),
      .stall_set(stall_set), .running(running)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          stall_q <= 1'b0;
      else if (stall_set)  stall_q <= 1'b1;
      else if (stall_rd)   stall_q <= 1'b0;
   end

   assign stall_flag = stall_q;
   assign idle       = !running && (tx_count == '0) && stall_q;
   assign sck        = sck_int ^ cpol;
endmodule

// File: rtl/spifs_checks.sv
module spifs_checks #(
   parameter int FIFO_DEPTH = 4,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             cpol,
   input logic             sck,
   input logic             tx_take,
   input logic             rx_put,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] tx_count,
   input logic             stall_flag,
   input logic             stall_rd
);
   AST_PARK_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ((sck ^ cpol) == 1'b0)); // R10

   AST_BYTE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> ((sck ^ cpol) == 1'b0)); // R5

   AST_NO_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CNT_W'(FIFO_DEPTH)) |-> !rx_put); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_flag && !stall_rd) |=> stall_flag); // R7

   AST_FLAG_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_flag) |-> $past(tx_count == '0)); // R7
endmodule

bind spi_frac_shifter spifs_checks #(.FIFO_DEPTH(FIFO_DEPTH)) u_checks (
   .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .sck(sck),
   .tx_take(tx_take), .rx_put(rx_put), .rx_count(rx_count),
   .tx_count(tx_count), .stall_flag(stall_flag), .stall_rd(stall_rd)
);

// File: tb/spi_frac_shifter_bench.sv
module spi_frac_shifter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n, en, cpol, cpha;
   logic [15:0] div_int;
   logic [7:0]  div_frac;
   logic [7:0]  tx_data, rx_data;
   logic        tx_valid, tx_ready, rx_valid, rx_ready;
   logic        stall_rd, stall_flag, idle, sck, mosi, miso;
   logic        inv_loop, sb_on;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   assign miso = inv_loop ? ~mosi : mosi;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_frac_shifter #(.FIFO_DEPTH(DEPTH)) u_spi_frac_shifter (
      .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
      .div_int(div_int), .div_frac(div_frac),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .stall_rd(stall_rd), .stall_flag(stall_flag), .idle(idle),
      .sck(sck), .mosi(mosi), .miso(miso)
   );

   task automatic ck(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // behavioural reference
   logic [7:0] sent_q[$];
   logic [7:0] m_txq[$];
   logic [7:0] m_rxq[$];
   int         m_acc, m_slot, m_bit;
   bit         m_run, m_flag;
   logic       m_mosi, miso_s;
   logic [7:0] m_txsh, m_rxsh;

   always @(posedge clk) begin : ref_model
      int ratio;
      bit tick, last, put, start, empty_tx, pop_rx, push_tx;
      logic [7:0] head, exp_b;
      if (!rst_n) begin
         m_acc = 0; m_run = 0; m_slot = 0; m_bit = 0;
         m_txsh = 0; m_rxsh = 0; m_mosi = 0; m_flag = 0;
         m_txq.delete(); m_rxq.delete();
      end else begin
         ratio    = ((div_int == 0) ? 1 : int'(div_int)) * 256 + int'(div_frac);
         tick     = en && (m_acc + 256 >= ratio);
         last     = m_run && m_slot == 3 && m_bit == 7;
         put      = tick && last;
         empty_tx = (m_txq.size() == 0);
         start    = tick && (!m_run || last) && !empty_tx &&
                    (m_rxq.size() + (put ? 1 : 0) < DEPTH);
         push_tx  = tx_valid && (m_txq.size() < DEPTH);
         pop_rx   = rx_ready && (m_rxq.size() > 0);
         if (pop_rx && sb_on) begin
            if (sent_q.size() == 0) ck(0, "R6 unexpected received byte", int'(rx_data), -1);
            else begin
               exp_b = sent_q.pop_front() ^ {8{inv_loop}};
               ck(rx_data == exp_b, "R6 loopback byte", int'(rx_data), int'(exp_b));
            end
         end
         if (pop_rx) void'(m_rxq.pop_front());
         if (put) m_rxq.push_back(m_rxsh);
         head = empty_tx ? 8'h00 : m_txq[0];
         if (start) void'(m_txq.pop_front());
         if (push_tx) m_txq.push_back(tx_data);
         if (put && empty_tx) m_flag = 1;
         else if (stall_rd) m_flag = 0;
         m_acc = !en ? 0 : (tick ? m_acc + 256 - ratio : m_acc + 256);
         if (!en) begin
            m_run = 0; m_slot = 0; m_bit = 0;
         end else if (tick) begin
            if (!m_run || last) begin
               m_slot = 0; m_bit = 0; m_run = start;
               if (start) begin
                  m_txsh = head;
                  if (!cpha) m_mosi = head[7];
               end
            end else begin
               if ((cpha && m_slot == 2) || (!cpha && m_slot == 1))
                  m_rxsh = {m_rxsh[6:0], miso_s};
               if (cpha && m_slot == 0) m_mosi = m_txsh[7];
               if (m_slot == 3) begin
                  if (!cpha) m_mosi = m_txsh[6];
                  m_txsh = m_txsh << 1;
                  m_bit++;
                  m_slot = 0;
               end else m_slot++;
            end
         end
      end
   end

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin : monitor
      logic exp_sck;
      miso_s = miso;
      cyc++;
      if (cyc > WATCHDOG) begin
         ck(0, "R6 watchdog expired", cyc, WATCHDOG);
         finish_run();
      end
      if (rst_n === 1'b1) begin
         exp_sck = (m_run && (cpha ? (m_slot == 1 || m_slot == 2) : (m_slot >= 2))) ^ cpol;
         ck(sck == exp_sck, cpha ? "R2 R4 sck" : "R2 R3 sck", int'(sck), int'(exp_sck));
         ck(mosi == m_mosi, cpha ? "R4 mosi" : "R3 mosi", int'(mosi), int'(m_mosi));
         ck(tx_ready == (m_txq.size() < DEPTH), "R11 tx_ready", int'(tx_ready), int'(m_txq.size() < DEPTH));
         ck(rx_valid == (m_rxq.size() > 0), "R11 rx_valid", int'(rx_valid), int'(m_rxq.size() > 0));
         if (m_rxq.size() > 0)
            ck(rx_data == m_rxq[0], "R11 rx_data", int'(rx_data), int'(m_rxq[0]));
         ck(stall_flag == m_flag, "R7 stall_flag", int'(stall_flag), int'(m_flag));
         ck(idle == (!m_run && m_txq.size() == 0 && m_flag), "R8 idle", int'(idle),
            int'(!m_run && m_txq.size() == 0 && m_flag));
      end
   end

   task automatic send(input logic [7:0] b);
      tx_data  = b;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      sent_q.push_back(b);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (!idle && n < 5000) begin
         @(negedge clk);
         n++;
      end
      ck(idle == 1'b1, "R8 transfer end reached", int'(idle), 1);
   endtask

   task automatic clear_flag();
      @(negedge clk); stall_rd = 1'b1;
      @(negedge clk); stall_rd = 1'b0;
      ck(stall_flag == 1'b0, "R7 cleared by read", int'(stall_flag), 0);
      ck(idle == 1'b0, "R8 idle drops with flag", int'(idle), 0);
   endtask

   task automatic set_mode(input bit pol, input bit pha, input int di, input int df);
      @(negedge clk); en = 1'b0;
      cpol = pol; cpha = pha; div_int = 16'(di); div_frac = 8'(df);
      @(negedge clk); en = 1'b1;
   endtask

   initial begin
      rst_n = 0; en = 0; cpol = 0; cpha = 0; div_int = 16'd1; div_frac = 8'd0;
      tx_data = 0; tx_valid = 0; rx_ready = 1; stall_rd = 0; inv_loop = 0; sb_on = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      ck(sck == 1'b0, "R1 sck idle", int'(sck), 0);
      ck(mosi == 1'b0, "R1 mosi low", int'(mosi), 0);
      ck(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
      ck(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
      ck(stall_flag == 1'b0, "R1 stall_flag", int'(stall_flag), 0);
      ck(idle == 1'b0, "R1 idle", int'(idle), 0);

      // all four modes at several rate values, loopback
      for (int m = 0; m < 4; m++) begin
         int di, df;
         di = (m == 0) ? 1 : (m == 1) ? 1 : (m == 2) ? 2 : 0;
         df = (m == 0) ? 0 : (m == 1) ? 128 : (m == 2) ? 64 : 0;
         set_mode(m >= 2, (m % 2) == 1, di, df);
         for (int k = 0; k < 5; k++) send(8'((8'hA5 ^ (m * 37 + k * 19)) & 255));
         wait_idle();
         ck(sck == cpol, "R5 parked at polarity", int'(sck), int'(cpol));
         ck(stall_flag == 1'b1, "R7 set at end", int'(stall_flag), 1);
         repeat (4) @(negedge clk);
         ck(sent_q.size() == 0, "R6 all bytes returned", sent_q.size(), 0);
         clear_flag();
      end

      // receive backpressure
      set_mode(0, 0, 1, 0);
      rx_ready = 1'b0;
      for (int k = 0; k < 6; k++) send(8'(k * 41 + 3));
      repeat (300) @(negedge clk);
      ck(rx_valid == 1'b1, "R9 held bytes kept", int'(rx_valid), 1);
      ck(sck == cpol, "R9 sck idle while held", int'(sck), int'(cpol));
      ck(stall_flag == 1'b0, "R9 no stall flag", int'(stall_flag), 0);
      rx_ready = 1'b1;
      wait_idle();
      repeat (6) @(negedge clk);
      ck(sent_q.size() == 0, "R9 nothing dropped", sent_q.size(), 0);
      clear_flag();

      // disable in the middle of a byte
      sb_on = 0;
      set_mode(1, 0, 2, 0);
      for (int k = 0; k < 3; k++) send(8'(8'h3C + k));
      repeat (12) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      ck(sck == cpol, "R10 parked after disable", int'(sck), int'(cpol));
      repeat (3) @(negedge clk);
      ck(sck == cpol, "R10 stays parked", int'(sck), int'(cpol));
      en = 1'b1;
      wait_idle();
      repeat (10) @(negedge clk);
      sent_q.delete();
      sb_on = 1;
      clear_flag();

      // inverted loopback checks sampling polarity of data
      inv_loop = 1;
      set_mode(1, 1, 1, 192);
      for (int k = 0; k < 4; k++) send(8'(8'h81 ^ (k * 53)));
      wait_idle();
      repeat (6) @(negedge clk);
      ck(sent_q.size() == 0, "R6 inverted bytes returned", sent_q.size(), 0);
      inv_loop = 0;
      clear_flag();

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule